// File: doc/BRIEF.md
# Filtered Quadrature Encoder Counter

This block decodes the two phase signals of an incremental rotary sensor into a position count. Each phase passes through its own synchronizer and glitch filter. The filtered pair is then decoded on every valid edge of either phase, which gives four counts per quadrature cycle. The count goes up or down to follow the direction of rotation. It stays between zero and a programmable reload limit and wraps at either end.

Counting happens only while the timer is enabled and set to continuous mode. In any other state the count is frozen, but the decoder keeps tracking the phases, so that re-enabling does not produce a spurious step. Two one-cycle flags mark a reversal of direction: one for up to down and one for down to up. The first edge after the block starts running only sets the direction and raises no flag.

Top module: `quad_enc_counter`

## Requirements
- R1: After reset, `count` is 0, `dirDown` is 0, and both direction flags are 0.
- R2: A pulse on either phase that lasts fewer than FILT_LEN clock cycles (4 by default) does not change `count`, `dirDown` or either flag.
- R3: When phaseA leads phaseB, every valid edge of either phase adds one to `count`. The forward state sequence for {phaseA,phaseB} is 00, 10, 11, 01, 00.
- R4: When phaseB leads phaseA, every valid edge subtracts one from `count`. This is the state sequence 00, 01, 11, 10, 00.
- R5: A forward step taken when `count` is greater than or equal to `reloadVal` sets `count` to 0.
- R6: A reverse step taken when `count` is 0 sets `count` to `reloadVal`.
- R7: While `enable` is 0 or `contMode` is 0, `count` holds its value whatever the phases do. Phase edges seen in that time cause no step once running resumes.
- R8: A transition in which both filtered phases change in the same cycle is ignored. It leaves `count`, `dirDown` and both flags unchanged.
- R9: `upToDownFlag` pulses high for exactly one cycle when a reverse step follows a forward step while running.
- R10: `downToUpFlag` pulses high for exactly one cycle when a forward step follows a reverse step while running.
- R11: The first valid edge after running starts (enable and continuous mode both set) raises no direction flag.
- R12: `dirDown` is 1 after a reverse step and 0 after a forward step, and it holds between steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Timer enable |
| contMode | input | 1 | 1 selects continuous mode; encoder counting needs it |
| phaseA | input | 1 | Raw quadrature phase 1 |
| phaseB | input | 1 | Raw quadrature phase 2 |
| reloadVal | input | CNT_W | Upper wrap limit of the count |
| count | output | CNT_W | Position count |
| dirDown | output | 1 | Direction of the last valid step, 1 = down |
| upToDownFlag | output | 1 | One-cycle pulse on a reversal from up to down |
| downToUpFlag | output | 1 | One-cycle pulse on a reversal from down to up |

## Verification
Forward and reverse walks through the phase sequence tell increments apart from decrements. They also expose a swapped lead rule, and walks that cross zero or the reload limit separate wrapping from saturation. Short glitches and simultaneous changes on both phases show whether the filter and the illegal-transition guard keep the count and direction intact. Toggling enable and continuous mode between steps, followed by a reversal, checks both the hold and the suppression of a flag on the first edge. A seeded random walk mixes all of these against a bench model of the count, the direction and the number of flags seen.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDown;
  } stepStrobe_t;
endpackage

// File: rtl/qenc_glitch_filter.sv
module qenc_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic [CW-1:0]          stableCnt;
  logic                   syncOut;

  assign syncOut = syncReg[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_oneStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= rawIn;
      end
    end else begin : g_multiStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg <= '0;
        else       syncReg <= {syncReg[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  // The output only follows once the synchronized value has differed for FILT_LEN cycles in a row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stableCnt <= '0;
      filtOut   <= 1'b0;
    end else if (syncOut != filtOut) begin
      if (stableCnt == CW'(FILT_LEN - 1)) begin
        filtOut   <= syncOut;
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + CW'(1);
      end
    end else begin
      stableCnt <= '0;
    end
  end
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        run,
  input  logic        fltA,
  input  logic        fltB,
  output stepStrobe_t strobe,
  output logic        dirDown,
  output logic        upToDownFlag,
  output logic        downToUpFlag
);
  logic prevA, prevB;
  logic chA, chB, validEdge, isUp;
  logic dirSeen;

  // The previous phases are tracked even while halted, so resuming does not see a stale edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= fltA;
      prevB <= fltB;
    end
  end

  always_comb begin
    chA       = fltA ^ prevA;
    chB       = fltB ^ prevB;
    validEdge = chA ^ chB;
    isUp      = chA ? (fltA != fltB) : (fltB == fltA);
    strobe.stepUp   = run & validEdge & isUp;
    strobe.stepDown = run & validEdge & ~isUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirDown      <= 1'b0;
      dirSeen      <= 1'b0;
      upToDownFlag <= 1'b0;
      downToUpFlag <= 1'b0;
    end else begin
      upToDownFlag <= 1'b0;
      downToUpFlag <= 1'b0;
      if (!run) begin
        dirSeen <= 1'b0;
      end else if (validEdge) begin
        dirSeen <= 1'b1;
        dirDown <= ~isUp;
        if (dirSeen && !isUp && !dirDown) upToDownFlag <= 1'b1;
        if (dirSeen && isUp && dirDown)   downToUpFlag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepStrobe_t      strobe,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] nextCount;

  always_comb begin
    nextCount = count;
    if (strobe.stepUp) begin
      nextCount = (count >= reloadVal) ? '0 : count + CNT_W'(1);
    end else if (strobe.stepDown) begin
      nextCount = (count == '0) ? reloadVal : count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else       count <= nextCount;
  end
endmodule

// File: rtl/quad_enc_counter.sv
module quad_enc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             contMode,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] count,
  output logic             dirDown,
  output logic             upToDownFlag,
  output logic             downToUpFlag
);
  localparam int N_PH = 2;

  logic [N_PH-1:0] rawPh, fltPh;
  stepStrobe_t     strobe;
  logic            run;

  assign rawPh = {phaseB, phaseA};
  assign run   = enable & contMode;

  for (genvar i = 0; i < N_PH; i++) begin : g_filt
    qenc_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .rawIn  (rawPh[i]),
      .filtOut(fltPh[i])
    );
  end

  qenc_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .run         (run),
    .fltA        (fltPh[0]),
    .fltB        (fltPh[1]),
    .strobe      (strobe),
    .dirDown     (dirDown),
    .upToDownFlag(upToDownFlag),
    .downToUpFlag(downToUpFlag)
  );

  qenc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reloadVal(reloadVal),
    .count    (count)
  );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             contMode,
  input logic [CNT_W-1:0] reloadVal,
  input logic [CNT_W-1:0] count,
  input logic             dirDown,
  input logic             upToDownFlag,
  input logic             downToUpFlag
);
  // R7: the count is frozen in any cycle that follows a halted cycle
  a_r7_hold_when_halted: assert property (@(posedge clk) disable iff (!rstN)
    !(enable && contMode) |=> $stable(count));

  // R9: an up-to-down flag coincides with the direction turning down
  a_r9_up_to_down: assert property (@(posedge clk) disable iff (!rstN)
    upToDownFlag |-> (dirDown && !$past(dirDown)));

  // R10: a down-to-up flag coincides with the direction turning up
  a_r10_down_to_up: assert property (@(posedge clk) disable iff (!rstN)
    downToUpFlag |-> (!dirDown && $past(dirDown)));

  // R9 and R10: the two reversal flags never fire together
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(upToDownFlag && downToUpFlag));

  // R5 and R6: a count change is a single step or a wrap
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(count) |-> (count == $past(count) + CNT_W'(1) ||
                         count == $past(count) - CNT_W'(1) ||
                         count == '0 || count == $past(reloadVal)));
endmodule

bind quad_enc_counter qenc_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .contMode    (contMode),
  .reloadVal   (reloadVal),
  .count       (count),
  .dirDown     (dirDown),
  .upToDownFlag(upToDownFlag),
  .downToUpFlag(downToUpFlag)
);

// File: tb/sim_quad_enc_counter.sv
`timescale 1ns/1ps
module sim_quad_enc_counter;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic             contMode = 1'b0;
  logic             phaseA = 1'b0;
  logic             phaseB = 1'b0;
  logic [CNT_W-1:0] reloadVal = '0;
  logic [CNT_W-1:0] count;
  logic             dirDown, upToDownFlag, downToUpFlag;

  int nChecks = 0;
  int nFail = 0;
  int u2dSeen = 0;
  int d2uSeen = 0;

  // model state
  int mCount = 0;
  bit mDown = 0;
  bit mSeen = 0;
  int mU2D = 0;
  int mD2U = 0;
  int pos = 0;

  always #2.5 clk = ~clk;

  quad_enc_counter u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .contMode(contMode),
    .phaseA(phaseA), .phaseB(phaseB), .reloadVal(reloadVal),
    .count(count), .dirDown(dirDown),
    .upToDownFlag(upToDownFlag), .downToUpFlag(downToUpFlag)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (upToDownFlag) u2dSeen++;
      if (downToUpFlag) d2uSeen++;
    end
  end

  function automatic int nextCnt(int c, bit up, int rl);
    if (up) return (c >= rl) ? 0 : c + 1;
    return (c == 0) ? rl : c - 1;
  endfunction

  function automatic bit running();
    return enable && contMode;
  endfunction

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (16) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drivePos();
    @(negedge clk);
    phaseA = (pos == 1 || pos == 2);
    phaseB = (pos == 2 || pos == 3);
  endtask

  task automatic checkAll(string req);
    chk({req, " count"}, int'(count), mCount);
    chk({req, " R12 dirDown"}, int'(dirDown), int'(mDown));
    chk({req, " R9 up-to-down flags"}, u2dSeen, mU2D);
    chk({req, " R10 down-to-up flags"}, d2uSeen, mD2U);
  endtask

  task automatic step(bit up);
    pos = up ? (pos + 1) % 4 : (pos + 3) % 4;
    if (running()) begin
      mCount = nextCnt(mCount, up, int'(reloadVal));
      if (mSeen && !up && !mDown) mU2D++;
      if (mSeen && up && mDown) mD2U++;
      mDown = !up;
      mSeen = 1;
    end
    drivePos();
    settle();
    checkAll(running() ? (up ? "R3" : "R4") : "R7");
  endtask

  task automatic setRun(bit en, bit cm);
    @(negedge clk);
    enable = en;
    contMode = cm;
    if (!(en && cm)) mSeen = 0;
  endtask

  task automatic glitch(bit onA, int width);
    @(negedge clk);
    if (onA) phaseA = ~phaseA; else phaseB = ~phaseB;
    repeat (width) @(negedge clk);
    if (onA) phaseA = ~phaseA; else phaseB = ~phaseB;
    settle();
    checkAll("R2 glitch");
  endtask

  task automatic illegal();
    pos = (pos + 2) % 4;
    drivePos();
    settle();
    checkAll("R8 illegal");
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 count in reset", int'(count), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 dirDown", int'(dirDown), 0);
    chk("R1 flags", int'(upToDownFlag) + int'(downToUpFlag), 0);

    reloadVal = 16'd5;
    setRun(1, 1);
    // R11: first edge sets direction only
    step(0);
    chk("R11 no flag on first edge", u2dSeen + d2uSeen, 0);
    chk("R6 wrap down from zero", int'(count), 5);
    for (int i = 0; i < 6; i++) step(1);
    chk("R5 wrap up past reload", int'(count), 5);
    step(1);
    chk("R5 wrap to zero", int'(count), 0);
    chk("R10 reversal flagged once", d2uSeen, 1);
    step(1);
    step(0);
    chk("R9 reversal flagged", u2dSeen, 1);
    step(1);
    chk("R10 second reversal", d2uSeen, 2);

    // R7: halted in non-continuous mode
    setRun(1, 0);
    step(0);
    step(0);
    chk("R7 hold with contMode low", int'(count), mCount);
    setRun(1, 1);
    step(0);
    chk("R11 no flag after re-enable", u2dSeen, mU2D);
    setRun(0, 1);
    step(1);
    setRun(1, 1);
    step(0);

    glitch(1, 2);
    glitch(0, 1);
    illegal();
    illegal();
    chk("R8 direction kept", int'(dirDown), int'(mDown));

    // seeded random walk
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom % 20;
      if (r == 0) glitch($urandom % 2, 1 + $urandom % 2);
      else if (r == 1) illegal();
      else if (r == 2) setRun($urandom % 4 != 0, $urandom % 4 != 0);
      else if (r == 3) begin
        @(negedge clk);
        reloadVal = CNT_W'($urandom % 40);
      end else step($urandom % 3 != 0 ? (i / 40) % 2 == 0 : (i / 40) % 2 != 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule